// File: doc/BRIEF.md
# Set-Associative Translation Cache with Permission Check

This block caches page translations for a processor's memory pipeline. A lookup presents a virtual page number, a page offset, and two access qualifiers: write or read, and user or supervisor mode. The low bits of the page number select one set. The remaining bits are compared against the tags of every way in that set. One cycle later the block returns a registered verdict: a hit with the physical address, a miss, a request to update the dirty bit, or a protection fault.

An external table walker handles every verdict other than a hit. It writes entries back through a refill port. A refill whose tag is already present in its set overwrites that entry, which is how the walker turns a clean entry dirty. Otherwise the refill takes the lowest-numbered invalid way. If the set is full, it evicts the way named by a per-set tree pseudo-LRU, which is updated on lookup hits and on refills.

Two flush inputs clear the cache in a single cycle. The local flush removes only entries that are not marked global. The full flush removes every entry.

Top module: `tlb_xlate`

## Requirements
- R1: After reset every entry is invalid and `res_valid` is low, so the first lookup of any page returns a miss.
- R2: A lookup presented with `lk_valid` high on one clock edge produces `res_valid` high together with its verdict after that edge, for exactly one cycle. `res_kind` is encoded as 0 hit, 1 miss, 2 dirty update, 3 protection fault.
- R3: The set index is bits [3:0] of the virtual page number and the tag is bits [19:4]. A lookup hits only on a valid entry in the indexed set whose tag is equal. An equal tag stored in a different set gives a miss.
- R4: On a hit `res_paddr` is the stored 20-bit physical page number in bits [31:12] and the unchanged 12-bit offset in bits [11:0]. For every other verdict `res_paddr` is zero.
- R5: A user-mode access (`lk_user`=1) to a supervisor-only entry, or a write to a non-writable entry, returns a protection fault. A protection fault takes precedence over a dirty update.
- R6: A permitted write that hits an entry with its dirty flag clear returns a dirty update. A read of the same entry returns a hit.
- R7: A refill whose tag already matches an entry in its set overwrites that entry in place, so later lookups return the new physical page number and flags.
- R8: A refill into a set that has invalid ways uses the lowest-numbered invalid way and evicts nothing.
- R9: A refill into a full set evicts the way named by the set's tree pseudo-LRU. Each node of the tree is pointed away from the most recent hit or refill.
- R10: `flush_local` clears every entry whose global flag is clear and keeps global entries. `flush_all` clears every entry. A refill in the same cycle as either flush is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_valid | input | 1 | Lookup request this cycle |
| lk_vpn | input | 20 | Virtual page number to translate |
| lk_off | input | 12 | Page offset, passed through on a hit |
| lk_write | input | 1 | Access is a write |
| lk_user | input | 1 | Access is made in user mode |
| res_valid | output | 1 | Verdict for the previous cycle's lookup |
| res_kind | output | 2 | 0 hit, 1 miss, 2 dirty update, 3 protection fault |
| res_paddr | output | 32 | Physical address on a hit, otherwise zero |
| fill_en | input | 1 | Refill write this cycle |
| fill_vpn | input | 20 | Virtual page number of the refilled entry |
| fill_ppn | input | 20 | Physical page number to store |
| fill_global | input | 1 | Entry survives a local flush |
| fill_super | input | 1 | Entry is supervisor-only |
| fill_writable | input | 1 | Entry permits writes |
| fill_dirty | input | 1 | Page is already marked dirty |
| flush_local | input | 1 | Invalidate all non-global entries |
| flush_all | input | 1 | Invalidate all entries |

## Verification
A corrupted tag, valid bit or flag shows up at the ports on the very next lookup of that page: it returns the wrong verdict or the wrong page number one cycle after the request. Wrong replacement state stays hidden until a full set is refilled. It then appears as a miss on a page that should have survived, or a hit on a page that should have been evicted. The bench therefore drives a set through a sequence of refills and hits whose victim order it has worked out in advance. A flush that spares too many or too few entries is exposed by looking up one global page and one private page right after the flush.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
   typedef enum logic [1:0] {
      RES_HIT   = 2'd0,
      RES_MISS  = 2'd1,
      RES_DIRTY = 2'd2,
      RES_PROT  = 2'd3
   } tlb_res_e;

   typedef struct packed {
      logic glob;
      logic sup;
      logic wr;
      logic dirty;
   } tlb_attr_t;
endpackage

// File: rtl/tlb_store.sv
// Entry storage: valid bits with reset and flush, data arrays written by refill.
module tlb_store
   import tlb_pkg::*;
#(
   parameter int SETS  = 16,
   parameter int WAYS  = 4,
   parameter int TAG_W = 16,
   parameter int PPN_W = 20,
   localparam int SET_W = $clog2(SETS),
   localparam int WAY_W = $clog2(WAYS)
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic                            flush_all,
   input  logic                            flush_local,
   input  logic                            wr_en,
   input  logic [SET_W-1:0]                wr_set,
   input  logic [WAY_W-1:0]                wr_way,
   input  logic [TAG_W-1:0]                wr_tag,
   input  logic [PPN_W-1:0]                wr_ppn,
   input  tlb_attr_t                       wr_attr,
   input  logic [SET_W-1:0]                a_set,
   output logic [WAYS-1:0]                 a_valid,
   output logic [WAYS-1:0][TAG_W-1:0]      a_tag,
   output logic [WAYS-1:0][PPN_W-1:0]      a_ppn,
   output tlb_attr_t [WAYS-1:0]            a_attr,
   input  logic [SET_W-1:0]                b_set,
   output logic [WAYS-1:0]                 b_valid,
   output logic [WAYS-1:0][TAG_W-1:0]      b_tag
);
   logic [WAYS-1:0]            valid_q [SETS];
   logic [WAYS-1:0][TAG_W-1:0] tag_q   [SETS];
   logic [WAYS-1:0][PPN_W-1:0] ppn_q   [SETS];
   tlb_attr_t [WAYS-1:0]       attr_q  [SETS];

   logic write_ok;
   assign write_ok = wr_en && !flush_all && !flush_local;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int s = 0; s < SETS; s++) valid_q[s] <= '0;
      end else if (flush_all) begin
         for (int s = 0; s < SETS; s++) valid_q[s] <= '0;
      end else if (flush_local) begin
         for (int s = 0; s < SETS; s++)
            for (int w = 0; w < WAYS; w++)
               if (!attr_q[s][w].glob) valid_q[s][w] <= 1'b0;
      end else if (wr_en) begin
         valid_q[wr_set][wr_way] <= 1'b1;
      end
   end

   // Data fields carry no reset: every use is qualified by the valid bit.
   always_ff @(posedge clk) begin
      if (write_ok) begin
         tag_q[wr_set][wr_way]  <= wr_tag;
         ppn_q[wr_set][wr_way]  <= wr_ppn;
         attr_q[wr_set][wr_way] <= wr_attr;
      end
   end

   assign a_valid = valid_q[a_set];
   assign a_tag   = tag_q[a_set];
   assign a_ppn   = ppn_q[a_set];
   assign a_attr  = attr_q[a_set];
   assign b_valid = valid_q[b_set];
   assign b_tag   = tag_q[b_set];

   logic [SETS-1:0] live_any, live_private;
   always_comb begin
      for (int s = 0; s < SETS; s++) begin
         live_any[s]     = |valid_q[s];
         live_private[s] = 1'b0;
         for (int w = 0; w < WAYS; w++)
            if (valid_q[s][w] && !attr_q[s][w].glob) live_private[s] = 1'b1;
      end
   end

   AST_FULL_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
      $past(flush_all) |-> live_any == '0);                                  // R10
   AST_LOCAL_FLUSH_KEEPS_GLOBAL: assert property (@(posedge clk) disable iff (!rst_n)
      $past(flush_local) |-> live_private == '0);                            // R10
   AST_REFILL_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
      $past(write_ok) |-> valid_q[$past(wr_set)][$past(wr_way)]);            // R8
endmodule

// File: rtl/tlb_match.sv
// Parallel tag compare across the ways of one set.
module tlb_match #(
   parameter int WAYS  = 4,
   parameter int TAG_W = 16,
   localparam int WAY_W = $clog2(WAYS)
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic [WAYS-1:0]            ent_valid,
   input  logic [WAYS-1:0][TAG_W-1:0] ent_tag,
   input  logic [TAG_W-1:0]           key,
   output logic [WAYS-1:0]            hit_vec,
   output logic                       hit,
   output logic [WAY_W-1:0]           hit_way
);
   for (genvar w = 0; w < WAYS; w++) begin : g_cmp
      assign hit_vec[w] = ent_valid[w] && (ent_tag[w] == key);
   end

   assign hit = |hit_vec;

   always_comb begin
      hit_way = '0;
      for (int w = WAYS - 1; w >= 0; w--)
         if (hit_vec[w]) hit_way = WAY_W'(w);
   end

   AST_SINGLE_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(hit_vec));                                                    // R7
endmodule

// File: rtl/tlb_plru.sv
// Per-set binary-tree pseudo-LRU; a node bit of 1 points at the upper half.
module tlb_plru #(
   parameter int SETS = 16,
   parameter int WAYS = 4,
   localparam int SET_W = $clog2(SETS),
   localparam int WAY_W = $clog2(WAYS)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             a_en,
   input  logic [SET_W-1:0] a_set,
   input  logic [WAY_W-1:0] a_way,
   input  logic             b_en,
   input  logic [SET_W-1:0] b_set,
   input  logic [WAY_W-1:0] b_way,
   input  logic [SET_W-1:0] v_set,
   output logic [WAY_W-1:0] v_way
);
   typedef logic [WAYS-2:0] tree_t;

   function automatic tree_t touch(tree_t t_in, logic [WAY_W-1:0] way);
      tree_t t;
      int    node;
      logic  b;
      t    = t_in;
      node = 0;
      for (int lvl = 0; lvl < WAY_W; lvl++) begin
         b       = way[WAY_W-1-lvl];
         t[node] = ~b;
         node    = 2 * node + 1 + int'(b);
      end
      return t;
   endfunction

   function automatic logic [WAY_W-1:0] pick(tree_t t);
      logic [WAY_W-1:0] v;
      int               node;
      logic             b;
      v    = '0;
      node = 0;
      for (int lvl = 0; lvl < WAY_W; lvl++) begin
         b              = t[node];
         v[WAY_W-1-lvl] = b;
         node           = 2 * node + 1 + int'(b);
      end
      return v;
   endfunction

   tree_t tree_q [SETS];
   tree_t tree_d [SETS];

   always_comb begin
      for (int s = 0; s < SETS; s++) begin
         tree_d[s] = tree_q[s];
         if (a_en && a_set == SET_W'(s)) tree_d[s] = touch(tree_d[s], a_way);
         if (b_en && b_set == SET_W'(s)) tree_d[s] = touch(tree_d[s], b_way);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int s = 0; s < SETS; s++) tree_q[s] <= '0;
      end else begin
         for (int s = 0; s < SETS; s++) tree_q[s] <= tree_d[s];
      end
   end

   assign v_way = pick(tree_q[v_set]);
endmodule

// File: rtl/tlb_xlate.sv
module tlb_xlate
   import tlb_pkg::*;
#(
   parameter int VPN_W = 20,
   parameter int OFF_W = 12,
   parameter int PPN_W = 20,
   parameter int SETS  = 16,
   parameter int WAYS  = 4
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   lk_valid,
   input  logic [VPN_W-1:0]       lk_vpn,
   input  logic [OFF_W-1:0]       lk_off,
   input  logic                   lk_write,
   input  logic                   lk_user,
   output logic                   res_valid,
   output logic [1:0]             res_kind,
   output logic [PPN_W+OFF_W-1:0] res_paddr,
   input  logic                   fill_en,
   input  logic [VPN_W-1:0]       fill_vpn,
   input  logic [PPN_W-1:0]       fill_ppn,
   input  logic                   fill_global,
   input  logic                   fill_super,
   input  logic                   fill_writable,
   input  logic                   fill_dirty,
   input  logic                   flush_local,
   input  logic                   flush_all
);
   localparam int SET_W = $clog2(SETS);
   localparam int WAY_W = $clog2(WAYS);
   localparam int TAG_W = VPN_W - SET_W;
   localparam int PA_W  = PPN_W + OFF_W;

   if (SETS != (1 << SET_W) || SETS < 2) begin : g_bad_sets
      $error("SETS must be a power of two of at least 2");
   end
   if (WAYS != (1 << WAY_W) || WAYS < 2) begin : g_bad_ways
      $error("WAYS must be a power of two of at least 2");
   end
   if (TAG_W < 1) begin : g_bad_tag
      $error("VPN_W must exceed the set index width");
   end

   // ---------------- lookup path ----------------
   logic [SET_W-1:0] lk_set;
   logic [TAG_W-1:0] lk_tag;
   assign lk_set = lk_vpn[SET_W-1:0];
   assign lk_tag = lk_vpn[VPN_W-1:SET_W];

   logic [WAYS-1:0]            a_valid;
   logic [WAYS-1:0][TAG_W-1:0] a_tag;
   logic [WAYS-1:0][PPN_W-1:0] a_ppn;
   tlb_attr_t [WAYS-1:0]       a_attr;

   // ---------------- refill path ----------------
   logic [SET_W-1:0] f_set;
   logic [TAG_W-1:0] f_tag;
   assign f_set = fill_vpn[SET_W-1:0];
   assign f_tag = fill_vpn[VPN_W-1:SET_W];

   logic [WAYS-1:0]            b_valid;
   logic [WAYS-1:0][TAG_W-1:0] b_tag;
   logic [WAY_W-1:0]           fill_way;
   tlb_attr_t                  f_attr;
   assign f_attr = '{glob: fill_global, sup: fill_super, wr: fill_writable, dirty: fill_dirty};

   tlb_store #(.SETS(SETS), .WAYS(WAYS), .TAG_W(TAG_W), .PPN_W(PPN_W)) u_store (
      .clk        (clk),
      .rst_n      (rst_n),
      .flush_all  (flush_all),
      .flush_local(flush_local),
      .wr_en      (fill_en),
      .wr_set     (f_set),
      .wr_way     (fill_way),
      .wr_tag     (f_tag),
      .wr_ppn     (fill_ppn),
      .wr_attr    (f_attr),
      .a_set      (lk_set),
      .a_valid    (a_valid),
      .a_tag      (a_tag),
      .a_ppn      (a_ppn),
      .a_attr     (a_attr),
      .b_set      (f_set),
      .b_valid    (b_valid),
      .b_tag      (b_tag)
   );

   logic [WAYS-1:0]  l_vec;
   logic             l_hit;
   logic [WAY_W-1:0] l_way;

   tlb_match #(.WAYS(WAYS), .TAG_W(TAG_W)) u_lk_match (
      .clk      (clk),
      .rst_n    (rst_n),
      .ent_valid(a_valid),
      .ent_tag  (a_tag),
      .key      (lk_tag),
      .hit_vec  (l_vec),
      .hit      (l_hit),
      .hit_way  (l_way)
   );

   logic [WAYS-1:0]  f_vec;
   logic             f_hit;
   logic [WAY_W-1:0] f_way;

   tlb_match #(.WAYS(WAYS), .TAG_W(TAG_W)) u_fill_match (
      .clk      (clk),
      .rst_n    (rst_n),
      .ent_valid(b_valid),
      .ent_tag  (b_tag),
      .key      (f_tag),
      .hit_vec  (f_vec),
      .hit      (f_hit),
      .hit_way  (f_way)
   );

   // Verdict for the lookup in this cycle.
   tlb_attr_t        e_attr;
   logic [PPN_W-1:0] e_ppn;
   tlb_res_e         kind_d;
   logic [PA_W-1:0]  paddr_d;

   assign e_attr = a_attr[l_way];
   assign e_ppn  = a_ppn[l_way];

   always_comb begin
      if (!l_hit)
         kind_d = RES_MISS;
      else if ((lk_user && e_attr.sup) || (lk_write && !e_attr.wr))
         kind_d = RES_PROT;
      else if (lk_write && !e_attr.dirty)
         kind_d = RES_DIRTY;
      else
         kind_d = RES_HIT;
      paddr_d = (kind_d == RES_HIT) ? {e_ppn, lk_off} : '0;
   end

   // Refill way choice: same tag in place, then lowest invalid, then tree victim.
   logic             inv_any;
   logic [WAY_W-1:0] inv_way;
   logic [WAY_W-1:0] lru_way;
   logic             fill_ok;

   always_comb begin
      inv_any = 1'b0;
      inv_way = '0;
      for (int w = WAYS - 1; w >= 0; w--) begin
         if (!b_valid[w]) begin
            inv_any = 1'b1;
            inv_way = WAY_W'(w);
         end
      end
   end

   assign fill_way = f_hit ? f_way : (inv_any ? inv_way : lru_way);
   assign fill_ok  = fill_en && !flush_all && !flush_local;

   tlb_plru #(.SETS(SETS), .WAYS(WAYS)) u_plru (
      .clk  (clk),
      .rst_n(rst_n),
      .a_en (lk_valid && kind_d == RES_HIT),
      .a_set(lk_set),
      .a_way(l_way),
      .b_en (fill_ok),
      .b_set(f_set),
      .b_way(fill_way),
      .v_set(f_set),
      .v_way(lru_way)
   );

   // Registered result stage.
   logic            res_valid_q;
   tlb_res_e        res_kind_q;
   logic [PA_W-1:0] res_paddr_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         res_valid_q <= 1'b0;
         res_kind_q  <= RES_MISS;
         res_paddr_q <= '0;
      end else begin
         res_valid_q <= lk_valid;
         if (lk_valid) begin
            res_kind_q  <= kind_d;
            res_paddr_q <= paddr_d;
         end
      end
   end

   assign res_valid = res_valid_q;
   assign res_kind  = res_kind_q;
   assign res_paddr = res_paddr_q;

   AST_RESULT_FOLLOWS_REQUEST: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid |-> $past(lk_valid));                                        // R2
   AST_HIT_KEEPS_OFFSET: assert property (@(posedge clk) disable iff (!rst_n)
      (res_valid && res_kind == RES_HIT) |-> res_paddr[OFF_W-1:0] == $past(lk_off)); // R4
   AST_NON_HIT_ZERO_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
      (res_valid && res_kind != RES_HIT) |-> res_paddr == '0);               // R4
   AST_USER_NEVER_HITS_SUPER: assert property (@(posedge clk) disable iff (!rst_n)
      (lk_valid && l_hit && lk_user && e_attr.sup) |=> res_kind == RES_PROT); // R5
endmodule

// File: tb/tlb_xlate_tb.sv
`timescale 1ns/100ps
module tlb_xlate_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        lk_valid = 1'b0;
   logic [19:0] lk_vpn = '0;
   logic [11:0] lk_off = '0;
   logic        lk_write = 1'b0;
   logic        lk_user = 1'b0;
   logic        res_valid;
   logic [1:0]  res_kind;
   logic [31:0] res_paddr;
   logic        fill_en = 1'b0;
   logic [19:0] fill_vpn = '0;
   logic [19:0] fill_ppn = '0;
   logic        fill_global = 1'b0;
   logic        fill_super = 1'b0;
   logic        fill_writable = 1'b0;
   logic        fill_dirty = 1'b0;
   logic        flush_local = 1'b0;
   logic        flush_all = 1'b0;

   int n_checks = 0;
   int n_fail   = 0;
   bit finished = 1'b0;

   localparam logic [1:0] K_HIT = 2'd0, K_MISS = 2'd1, K_DIRTY = 2'd2, K_PROT = 2'd3;

   always #2.5 clk = ~clk;

   tlb_xlate u_dut (
      .clk(clk), .rst_n(rst_n),
      .lk_valid(lk_valid), .lk_vpn(lk_vpn), .lk_off(lk_off),
      .lk_write(lk_write), .lk_user(lk_user),
      .res_valid(res_valid), .res_kind(res_kind), .res_paddr(res_paddr),
      .fill_en(fill_en), .fill_vpn(fill_vpn), .fill_ppn(fill_ppn),
      .fill_global(fill_global), .fill_super(fill_super),
      .fill_writable(fill_writable), .fill_dirty(fill_dirty),
      .flush_local(flush_local), .flush_all(flush_all)
   );

   task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic fill(input logic [19:0] vpn, input logic [19:0] ppn,
                       input bit g, input bit s, input bit w, input bit d);
      @(negedge clk);
      fill_en = 1'b1; fill_vpn = vpn; fill_ppn = ppn;
      fill_global = g; fill_super = s; fill_writable = w; fill_dirty = d;
      @(negedge clk);
      fill_en = 1'b0;
   endtask

   // Drives one lookup, then samples the registered result one edge later.
   task automatic lookup(input logic [19:0] vpn, input logic [11:0] off,
                         input bit wr, input bit usr, input string req,
                         input logic [1:0] exp_kind, input logic [31:0] exp_pa);
      @(negedge clk);
      lk_valid = 1'b1; lk_vpn = vpn; lk_off = off; lk_write = wr; lk_user = usr;
      @(negedge clk);
      lk_valid = 1'b0;
      check(res_valid == 1'b1, {req, " valid"}, 64'(res_valid), 64'd1);
      check(res_kind == exp_kind, {req, " kind"}, 64'(res_kind), 64'(exp_kind));
      check(res_paddr == exp_pa, {req, " paddr"}, 64'(res_paddr), 64'(exp_pa));
   endtask

   task automatic pulse_flush(input bit all, input bit with_fill);
      @(negedge clk);
      if (all) flush_all = 1'b1; else flush_local = 1'b1;
      if (with_fill) begin
         fill_en = 1'b1; fill_vpn = 20'h000FF; fill_ppn = 20'h0F0F0;
         fill_global = 1'b1; fill_super = 1'b0; fill_writable = 1'b1; fill_dirty = 1'b1;
      end
      @(negedge clk);
      flush_all = 1'b0; flush_local = 1'b0; fill_en = 1'b0;
   endtask

   // {vpn[67:48], off[47:36], write[35], user[34], kind[33:32], paddr[31:0]}
   localparam int NV = 10;
   localparam logic [67:0] VECS [NV] = '{
      {20'h00013, 12'h123, 1'b1, 1'b1, K_HIT,   32'h0ABCD123},
      {20'h00023, 12'h000, 1'b0, 1'b1, K_PROT,  32'h00000000},
      {20'h00023, 12'hFFF, 1'b0, 1'b0, K_HIT,   32'h11111FFF},
      {20'h00033, 12'h456, 1'b1, 1'b0, K_PROT,  32'h00000000},
      {20'h00033, 12'h010, 1'b0, 1'b1, K_HIT,   32'h22222010},
      {20'h00045, 12'h777, 1'b1, 1'b1, K_DIRTY, 32'h00000000},
      {20'h00045, 12'h777, 1'b0, 1'b1, K_HIT,   32'h33333777},
      {20'h00053, 12'h000, 1'b0, 1'b0, K_MISS,  32'h00000000},
      {20'h00014, 12'h000, 1'b0, 1'b0, K_MISS,  32'h00000000},
      {20'h12347, 12'hABC, 1'b1, 1'b1, K_HIT,   32'h44444ABC}
   };

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      check(res_valid == 1'b0, "R1 reset valid", 64'(res_valid), 64'd0);
      rst_n = 1'b1;
      @(negedge clk);
      check(res_valid == 1'b0, "R1 idle after reset", 64'(res_valid), 64'd0);
      lookup(20'h00013, 12'h000, 1'b0, 1'b0, "R1 empty lookup", K_MISS, 32'h0);
      @(negedge clk);
      check(res_valid == 1'b0, "R2 single-cycle valid", 64'(res_valid), 64'd0);

      // Entries for the vector table.
      fill(20'h00013, 20'h0ABCD, 1'b0, 1'b0, 1'b1, 1'b1);
      fill(20'h00023, 20'h11111, 1'b0, 1'b1, 1'b1, 1'b1);
      fill(20'h00033, 20'h22222, 1'b0, 1'b0, 1'b0, 1'b0);
      fill(20'h00045, 20'h33333, 1'b0, 1'b0, 1'b1, 1'b0);
      fill(20'h12347, 20'h44444, 1'b1, 1'b0, 1'b1, 1'b1);

      // Vector table covers R3, R4, R5 and R6.
      for (int i = 0; i < NV; i++) begin
         lookup(VECS[i][67:48], VECS[i][47:36], VECS[i][35], VECS[i][34],
                $sformatf("R3 R4 R5 R6 vector %0d", i), VECS[i][33:32], VECS[i][31:0]);
      end

      // R7: refill with the same tag replaces the entry in place.
      fill(20'h00045, 20'h55555, 1'b0, 1'b0, 1'b1, 1'b1);
      lookup(20'h00045, 12'h001, 1'b1, 1'b1, "R7 refill in place", K_HIT, 32'h55555001);

      // R8: invalid ways are used before any eviction.
      fill(20'h0001A, 20'h00A01, 1'b0, 1'b0, 1'b1, 1'b1);
      fill(20'h0002A, 20'h00A02, 1'b0, 1'b0, 1'b1, 1'b1);
      lookup(20'h0001A, 12'h000, 1'b0, 1'b0, "R8 first kept", K_HIT, 32'h00A01000);
      lookup(20'h0002A, 12'h000, 1'b0, 1'b0, "R8 second kept", K_HIT, 32'h00A02000);

      // R9: tree victim order in set 9.
      for (int t = 1; t <= 4; t++) fill({16'(t), 4'h9}, 20'(32'h90000 + t), 1'b0, 1'b0, 1'b1, 1'b1);
      fill(20'h00059, 20'h90005, 1'b0, 1'b0, 1'b1, 1'b1);
      lookup(20'h00019, 12'h000, 1'b0, 1'b0, "R9 way0 evicted", K_MISS, 32'h0);
      lookup(20'h00029, 12'h000, 1'b0, 1'b0, "R9 way1 kept", K_HIT, 32'h90002000);
      fill(20'h00069, 20'h90006, 1'b0, 1'b0, 1'b1, 1'b1);
      lookup(20'h00039, 12'h000, 1'b0, 1'b0, "R9 way2 evicted", K_MISS, 32'h0);
      lookup(20'h00049, 12'h000, 1'b0, 1'b0, "R9 way3 kept", K_HIT, 32'h90004000);
      lookup(20'h00059, 12'h000, 1'b0, 1'b0, "R9 newer kept", K_HIT, 32'h90005000);
      lookup(20'h00069, 12'h000, 1'b0, 1'b0, "R9 newest kept", K_HIT, 32'h90006000);

      // R10: flushes.
      pulse_flush(1'b0, 1'b0);
      lookup(20'h00013, 12'h000, 1'b0, 1'b0, "R10 local flush private", K_MISS, 32'h0);
      lookup(20'h12347, 12'h002, 1'b0, 1'b0, "R10 local flush global", K_HIT, 32'h44444002);
      pulse_flush(1'b1, 1'b0);
      lookup(20'h12347, 12'h002, 1'b0, 1'b0, "R10 full flush global", K_MISS, 32'h0);
      pulse_flush(1'b1, 1'b1);
      lookup(20'h000FF, 12'h000, 1'b0, 1'b0, "R10 fill dropped by flush", K_MISS, 32'h0);

      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end
endmodule